// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block is the first stage of a small memory management unit. Each cycle it may accept one request: a 32-bit virtual address, an access kind (read, write or execute) and a flag that marks a user-mode access. It decides how that address is translated. With translation switched off, the address goes out unchanged with every permission granted. A kernel access that falls in a segment enabled for direct mapping has its top nibble replaced by a per-segment base nibble. Every other access is handed to an external page translator, and the page translator's answer is passed back.

The 4 GB space is split into sixteen 256 MB segments, numbered by the top four address bits. The sixteen base nibbles sit packed in two 32-bit registers, eight nibbles in each. The page translator is reached through a request port that drives the address, the access kind, the mode and an instruction-side select. It answers in the same cycle. The block registers the final result, so the response appears one clock after the request.

Top module: `segxl_top`

## Requirements
- R1: Translation is on when either bit of `cfg_mode_bits` is 1. When both are 0, the response carries `rsp_paddr` equal to the request address, `rsp_perm` = 3'b111 and `rsp_miss` = 0, and `pg_req` stays 0.
- R2: The segment number is `req_vaddr[31:28]`. A request is direct-mapped only when translation is on, `req_user` is 0 and `cfg_seg_en[segment]` is 1. A user-mode request never takes the direct-mapped path.
- R3: Segments 0 to 7 take their base nibble from `cfg_base_lo` and segments 8 to 15 from `cfg_base_hi`. Within the chosen register, segment s uses bits [4*(s mod 8)+3 : 4*(s mod 8)].
- R4: A direct-mapped response has `rsp_paddr` = {base nibble, `req_vaddr[27:0]`}, `rsp_perm` = 3'b111 and `rsp_miss` = 0, and `pg_req` stays 0.
- R5: A valid request with translation on that is not direct-mapped raises `pg_req` in the same cycle. `pg_vaddr`, `pg_acc` and `pg_user` then equal the request's address, access kind and mode.
- R6: `pg_insn` is 1 for an execute access (`req_acc` = 2) and 0 for a read (0) or a write (1).
- R7: For a request sent to the page translator, the response carries `pg_paddr`, `pg_perm` and `pg_miss` exactly as they were in the request cycle.
- R8: `rsp_valid` is 1 in the cycle after a valid request and 0 in the cycle after an idle one. After an idle cycle, `rsp_paddr`, `rsp_perm` and `rsp_miss` keep the values of the last response.
- R9: Under reset (`rst_n` low), `rsp_valid`, `rsp_paddr`, `rsp_perm` and `rsp_miss` are all 0.
- R10: The unused access code 3 is handled as a read: it selects the data side (`pg_insn` = 0).

Permission bits: bit 0 read, bit 1 write, bit 2 execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 treated as read |
| req_user | input | 1 | 1 for a user-mode access |
| cfg_mode_bits | input | 2 | Translation enable bits; either one set turns translation on |
| cfg_seg_en | input | 16 | Direct-map enable, one bit per segment (bit s for segment s) |
| cfg_base_lo | input | 32 | Packed base nibbles for segments 0 to 7 |
| cfg_base_hi | input | 32 | Packed base nibbles for segments 8 to 15 |
| pg_req | output | 1 | Request to the page translator |
| pg_insn | output | 1 | 1 selects the instruction-side page translator |
| pg_vaddr | output | 32 | Address forwarded to the page translator |
| pg_acc | output | 2 | Access kind forwarded to the page translator |
| pg_user | output | 1 | Mode forwarded to the page translator |
| pg_paddr | input | 32 | Physical address from the page translator |
| pg_perm | input | 3 | Permissions from the page translator |
| pg_miss | input | 1 | Miss flag from the page translator |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 3 | Granted permissions |
| rsp_miss | output | 1 | Translation miss |

## Verification
The page-translator request lines are combinational, so they are due in the same cycle as the request. The bench drives each request at a falling edge and checks `pg_req`, `pg_insn` and the forwarded fields one time unit later, before any clock edge. The response passes through one register. The bench therefore checks it at the next falling edge, after exactly one rising edge. Idle cycles are checked the same way, one falling edge later, for the dropped valid and the held fields.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    // Access kind encoding seen at the request port.
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Permission set, bit 0 read, bit 1 write, bit 2 execute.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    localparam perm_t PERM_ALL  = '{x: 1'b1, w: 1'b1, r: 1'b1};
    localparam perm_t PERM_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};

    // Path chosen for a request.
    typedef enum logic [1:0] {
        PATH_PASS   = 2'd0,
        PATH_DIRECT = 2'd1,
        PATH_PAGE   = 2'd2
    } path_e;

endpackage

// File: rtl/segxl_mode_dec.sv
module segxl_mode_dec #(
    parameter int unsigned SEG_W  = 4,
    parameter int unsigned MODE_W = 2,
    localparam int unsigned NSEG  = 1 << SEG_W
) (
    input  logic [MODE_W-1:0] mode_bits,
    input  logic [NSEG-1:0]   seg_en,
    input  logic [SEG_W-1:0]  seg,
    input  logic              user,
    output segxl_pkg::path_e  path
);
    import segxl_pkg::*;

    logic xl_on;
    logic seg_sel;

    always_comb begin
        xl_on   = |mode_bits;
        seg_sel = seg_en[seg];
        if (!xl_on) begin
            path = PATH_PASS;
        end else if (!user && seg_sel) begin
            path = PATH_DIRECT;
        end else begin
            path = PATH_PAGE;
        end
    end

endmodule

// File: rtl/segxl_seg_map.sv
module segxl_seg_map #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned SEG_W = 4,
    localparam int unsigned NSEG   = 1 << SEG_W,
    localparam int unsigned NIB    = NSEG / 2,
    localparam int unsigned IDX_W  = SEG_W - 1,
    localparam int unsigned BASE_W = NIB * SEG_W,
    localparam int unsigned OFF_W  = VA_W - SEG_W
) (
    input  logic [BASE_W-1:0] base_lo,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [VA_W-1:0]   vaddr,
    output logic [VA_W-1:0]   paddr
);

    logic [SEG_W-1:0] nib_lo [NIB];
    logic [SEG_W-1:0] nib_hi [NIB];

    for (genvar g = 0; g < NIB; g++) begin : g_unpack
        assign nib_lo[g] = base_lo[g*SEG_W +: SEG_W];
        assign nib_hi[g] = base_hi[g*SEG_W +: SEG_W];
    end

    logic [SEG_W-1:0] seg;
    logic [IDX_W-1:0] idx;
    logic [SEG_W-1:0] nib;

    always_comb begin
        seg   = vaddr[VA_W-1 -: SEG_W];
        idx   = seg[IDX_W-1:0];
        nib   = seg[SEG_W-1] ? nib_hi[idx] : nib_lo[idx];
        paddr = {nib, vaddr[OFF_W-1:0]};
    end

endmodule

// File: rtl/segxl_side_sel.sv
module segxl_side_sel (
    input  segxl_pkg::acc_e acc,
    output logic            insn
);
    import segxl_pkg::*;

    always_comb begin
        unique case (acc)
            ACC_EXEC: insn = 1'b1;
            ACC_READ,
            ACC_WRITE,
            ACC_RSVD: insn = 1'b0;
            default:  insn = 1'b0;
        endcase
    end

endmodule

// File: rtl/segxl_top.sv
module segxl_top #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned SEG_W  = 4,
    parameter int unsigned MODE_W = 2,
    localparam int unsigned NSEG   = 1 << SEG_W,
    localparam int unsigned BASE_W = (NSEG / 2) * SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [MODE_W-1:0] cfg_mode_bits,
    input  logic [NSEG-1:0]   cfg_seg_en,
    input  logic [BASE_W-1:0] cfg_base_lo,
    input  logic [BASE_W-1:0] cfg_base_hi,
    output logic              pg_req,
    output logic              pg_insn,
    output logic [VA_W-1:0]   pg_vaddr,
    output logic [1:0]        pg_acc,
    output logic              pg_user,
    input  logic [VA_W-1:0]   pg_paddr,
    input  logic [2:0]        pg_perm,
    input  logic              pg_miss,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [2:0]        rsp_perm,
    output logic              rsp_miss
);
    import segxl_pkg::*;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] paddr;
        perm_t           perm;
        logic            miss;
    } rsp_t;

    path_e           path;
    logic [VA_W-1:0] seg_paddr;
    acc_e            acc;
    logic            insn_sel;

    assign acc = acc_e'(req_acc);

    segxl_mode_dec #(
        .SEG_W  (SEG_W),
        .MODE_W (MODE_W)
    ) mode_dec_i (
        .mode_bits (cfg_mode_bits),
        .seg_en    (cfg_seg_en),
        .seg       (req_vaddr[VA_W-1 -: SEG_W]),
        .user      (req_user),
        .path      (path)
    );

    segxl_seg_map #(
        .VA_W  (VA_W),
        .SEG_W (SEG_W)
    ) seg_map_i (
        .base_lo (cfg_base_lo),
        .base_hi (cfg_base_hi),
        .vaddr   (req_vaddr),
        .paddr   (seg_paddr)
    );

    segxl_side_sel side_sel_i (
        .acc  (acc),
        .insn (insn_sel)
    );

    // Page translator port, combinational from the request.
    always_comb begin
        pg_req   = req_valid && (path == PATH_PAGE);
        pg_insn  = insn_sel;
        pg_vaddr = req_vaddr;
        pg_acc   = req_acc;
        pg_user  = req_user;
    end

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            unique case (path)
                PATH_PASS: begin
                    rsp_d.paddr = req_vaddr;
                    rsp_d.perm  = PERM_ALL;
                    rsp_d.miss  = 1'b0;
                end
                PATH_DIRECT: begin
                    rsp_d.paddr = seg_paddr;
                    rsp_d.perm  = PERM_ALL;
                    rsp_d.miss  = 1'b0;
                end
                default: begin
                    rsp_d.paddr = pg_paddr;
                    rsp_d.perm  = perm_t'(pg_perm);
                    rsp_d.miss  = pg_miss;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, paddr: '0, perm: PERM_NONE, miss: 1'b0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_miss  = rsp_q.miss;

endmodule

// File: rtl/segxl_checker.sv
module segxl_checker #(
    parameter int unsigned VA_W   = 32,
    parameter int unsigned SEG_W  = 4,
    parameter int unsigned MODE_W = 2,
    localparam int unsigned NSEG  = 1 << SEG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic [1:0]        req_acc,
    input logic              req_user,
    input logic [MODE_W-1:0] cfg_mode_bits,
    input logic [NSEG-1:0]   cfg_seg_en,
    input logic              pg_req,
    input logic              pg_insn,
    input logic [VA_W-1:0]   pg_paddr,
    input logic              pg_miss,
    input logic              rsp_valid,
    input logic [VA_W-1:0]   rsp_paddr,
    input logic [2:0]        rsp_perm,
    input logic              rsp_miss
);
    localparam int unsigned OFF_W = VA_W - SEG_W;

    logic on_c;
    logic direct_c;
    assign on_c     = |cfg_mode_bits;
    assign direct_c = on_c && !req_user && cfg_seg_en[req_vaddr[VA_W-1 -: SEG_W]];

    assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !on_c) |=> (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && !rsp_miss));

    assert_no_page_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !on_c |-> !pg_req);

    assert_user_goes_paged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && on_c && req_user) |-> pg_req);

    assert_direct_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && direct_c) |=> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])
                                     && rsp_perm == 3'b111 && !rsp_miss));

    assert_direct_no_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        direct_c |-> !pg_req);

    assert_page_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |-> req_valid);

    assert_exec_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_acc == 2'd2) |-> pg_insn);

    assert_forward_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_req |=> (rsp_paddr == $past(pg_paddr) && rsp_miss == $past(pg_miss)));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm) && $stable(rsp_miss)));

    assert_rsvd_data_side_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_acc == 2'd3) |-> !pg_insn);

endmodule

bind segxl_top segxl_checker #(
    .VA_W   (VA_W),
    .SEG_W  (SEG_W),
    .MODE_W (MODE_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_acc       (req_acc),
    .req_user      (req_user),
    .cfg_mode_bits (cfg_mode_bits),
    .cfg_seg_en    (cfg_seg_en),
    .pg_req        (pg_req),
    .pg_insn       (pg_insn),
    .pg_paddr      (pg_paddr),
    .pg_miss       (pg_miss),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_perm      (rsp_perm),
    .rsp_miss      (rsp_miss)
);

// File: tb/segxl_top_tb_top.sv
module segxl_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [1:0]  cfg_mode_bits = '0;
    logic [15:0] cfg_seg_en = '0;
    logic [31:0] cfg_base_lo = 32'h7654_3210;
    logic [31:0] cfg_base_hi = 32'hFEDC_BA98;
    logic        pg_req, pg_insn, pg_user;
    logic [31:0] pg_vaddr, pg_paddr;
    logic [1:0]  pg_acc;
    logic [2:0]  pg_perm;
    logic        pg_miss;
    logic        rsp_valid, rsp_miss;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Held expectations for the registered response
    logic [31:0] exp_paddr = '0;
    logic [2:0]  exp_perm  = '0;
    logic        exp_miss  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model of the external page translator
    function automatic logic [31:0] pt_paddr(logic [31:0] va, logic insn);
        return va ^ (insn ? 32'hA000_0F00 : 32'h5000_00F0);
    endfunction
    function automatic logic [2:0] pt_perm(logic [31:0] va, logic user);
        return va[2:0] ^ {user, 2'b00};
    endfunction
    function automatic logic pt_miss(logic [31:0] va, logic [1:0] acc);
        return va[7] ^ acc[0];
    endfunction

    assign pg_paddr = pt_paddr(pg_vaddr, pg_insn);
    assign pg_perm  = pt_perm(pg_vaddr, pg_user);
    assign pg_miss  = pt_miss(pg_vaddr, pg_acc);

    segxl_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .req_user      (req_user),
        .cfg_mode_bits (cfg_mode_bits),
        .cfg_seg_en    (cfg_seg_en),
        .cfg_base_lo   (cfg_base_lo),
        .cfg_base_hi   (cfg_base_hi),
        .pg_req        (pg_req),
        .pg_insn       (pg_insn),
        .pg_vaddr      (pg_vaddr),
        .pg_acc        (pg_acc),
        .pg_user       (pg_user),
        .pg_paddr      (pg_paddr),
        .pg_perm       (pg_perm),
        .pg_miss       (pg_miss),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_perm      (rsp_perm),
        .rsp_miss      (rsp_miss)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request: port checks in the same cycle, response one edge later.
    task automatic send(logic v, logic [31:0] va, logic [1:0] acc, logic user);
        logic        en, direct, insn, pgreq;
        logic [3:0]  seg, nib;
        logic [31:0] base;
        string       ptag;
        req_valid = v; req_vaddr = va; req_acc = acc; req_user = user;
        en     = |cfg_mode_bits;
        seg    = va[31:28];
        direct = en && !user && cfg_seg_en[seg];
        base   = seg[3] ? cfg_base_hi : cfg_base_lo;
        nib    = base[4*seg[2:0] +: 4];
        insn   = (acc == 2'd2);
        pgreq  = v && en && !direct;
        #1;
        check("R5 pg_req", {31'b0, pg_req}, {31'b0, pgreq});
        check(acc == 2'd3 ? "R10 pg_insn" : "R6 pg_insn", {31'b0, pg_insn}, {31'b0, insn});
        if (pgreq) begin
            check("R5 pg_vaddr", pg_vaddr, va);
            check("R5 pg_acc/user", {29'b0, pg_acc, pg_user}, {29'b0, acc, user});
        end
        if (v) begin
            if (!en) begin
                exp_paddr = va; exp_perm = 3'b111; exp_miss = 1'b0; ptag = "R1";
            end else if (direct) begin
                exp_paddr = {nib, va[27:0]}; exp_perm = 3'b111; exp_miss = 1'b0; ptag = "R3/R4";
            end else begin
                exp_paddr = pt_paddr(va, insn); exp_perm = pt_perm(va, user);
                exp_miss = pt_miss(va, acc); ptag = user ? "R2/R7" : "R7";
            end
        end else begin
            ptag = "R8";
        end
        @(negedge clk);
        check("R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, v});
        check({ptag, " rsp_paddr"}, rsp_paddr, exp_paddr);
        check({ptag, " rsp_perm/miss"}, {28'b0, rsp_perm, rsp_miss}, {28'b0, exp_perm, exp_miss});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R9 rsp_paddr", rsp_paddr, 32'd0);
        check("R9 rsp_perm/miss", {28'b0, rsp_perm, rsp_miss}, 32'd0);
        rst_n = 1'b1;

        // R1: translation off, even with all segments enabled
        cfg_mode_bits = 2'b00; cfg_seg_en = 16'hFFFF;
        send(1, 32'h8123_4567, 2'd0, 0);
        send(1, 32'hF000_0001, 2'd2, 0);
        send(1, 32'h0ABC_DEF0, 2'd1, 1);

        // R2/R3/R4: each segment direct-mapped, each enable bit alone
        for (int s = 0; s < 16; s++) begin
            cfg_mode_bits = (s % 2 == 0) ? 2'b01 : 2'b10;
            cfg_seg_en = 16'(1 << s);
            send(1, {4'(s), 28'($urandom)}, 2'd0, 0);
            // R5: same segment with its enable bit clear goes to the page port
            cfg_seg_en = ~16'(1 << s);
            send(1, {4'(s), 28'($urandom)}, 2'd1, 0);
            // R2: user mode bypasses segment mapping
            cfg_seg_en = 16'hFFFF;
            send(1, {4'(s), 28'($urandom)}, 2'($urandom_range(0, 2)), 1);
        end

        // R6/R10: access kinds on the page path
        cfg_mode_bits = 2'b11; cfg_seg_en = 16'h0000;
        send(1, 32'h1234_5680, 2'd2, 0);
        send(1, 32'h1234_5680, 2'd3, 0);
        send(1, 32'h2222_0005, 2'd3, 1);

        // R8: idle cycles hold the response fields
        send(0, 32'hDEAD_BEEF, 2'd2, 1);
        send(0, 32'h0000_0000, 2'd0, 0);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            cfg_mode_bits = 2'($urandom);
            cfg_seg_en    = 16'($urandom);
            cfg_base_lo   = $urandom;
            cfg_base_hi   = $urandom;
            send(($urandom_range(0, 7) != 0), $urandom, 2'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule